// File: doc/BRIEF.md
# Two-Stage Serial Bit-Clock Prescaler

This block turns a controller's functional clock into the bit clock of a synchronous serial port. The division happens in two cascaded stages. The first stage is global. A 2-bit selector picks a ratio of 2, 4, 7 or 10. The second stage is picked per frame from the mode field of the chip select in use, and its ratio is 2, 4 or 8. The serial clock period is the product of the two ratios. The slowest setting therefore divides the functional clock by 80.

A frame runs while both the enable input and the frame request are high. While a frame runs, the block produces three outputs. The first is the serial clock line, whose idle level can be inverted. The second is a one-cycle drive strobe, which tells the shifter when to present the next bit. The third is a one-cycle sample strobe, which tells it when to capture input. Each strobe sits on either the leading edge or the trailing edge of the bit, as chosen by per-chip configuration bits. At frame start all counters begin from zero, so the first bit is full length. The configuration is frozen for the whole frame.

Top module: `serclk_prescaler`

## Requirements
- R1: The first-stage ratio follows `div1_sel`: code 0 gives 2, code 1 gives 4, code 2 gives 7 and code 3 gives 10.
- R2: The second-stage ratio comes from bits [2c+1:2c] of `div2_sel_flat` for the chip c on `cs_idx`: code 0 gives 2, code 1 gives 4, and codes 2 and 3 both give 8.
- R3: While a frame runs, `sclk` has a period of exactly R1ratio*R2ratio functional clock cycles. It spends exactly half of that period at each level, so the slowest period is 80 cycles.
- R4: Counters restart at every frame start. A frame start is a clock edge at which `pre_en && frame_go` is high after an edge at which it was low. After a start, `sclk` stays at its idle level for the first half-period. Its first change, the leading edge, follows the edge that ends that half-period.
- R5: `drive_stb` is high for exactly one cycle, in the cycle in which `sclk` shows a new level. It fires only on leading edges (idle to active) when `drive_lead[c]` = 1, and only on trailing edges (active to idle) when `drive_lead[c]` = 0.
- R6: `sample_stb` behaves the same way as `drive_stb`, under the control of `sample_lead[c]`.
- R7: The idle level of `sclk` equals `idle_inv`. While a frame runs, the line is the non-inverted waveform (low at idle) XOR `idle_inv`.
- R8: After any clock edge at which `pre_en` or `frame_go` is low, `sclk` sits at `idle_inv` and both strobes are low. This holds whichever of the two inputs is low.
- R9: The block samples `div1_sel`, `cs_idx`, `div2_sel_flat`, `drive_lead` and `sample_lead` at every edge at which no frame runs. It uses the last such sample for the whole frame, so a change to these inputs during a frame has no effect on that frame.
- R10: While `rst_n` is low, `sclk` equals `idle_inv` and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_en | input | 1 | Prescaler enable; low stops the clock |
| frame_go | input | 1 | Frame request; a frame runs while it and pre_en are high |
| div1_sel | input | 2 | Global first-stage ratio code |
| idle_inv | input | 1 | Idle level of the serial clock line |
| cs_idx | input | 2 | Chip whose mode fields are used for the next frame |
| div2_sel_flat | input | 8 | Second-stage code per chip, 2 bits each, chip 0 in the low bits |
| drive_lead | input | 4 | Per chip: 1 = drive on leading edge, 0 = on trailing edge |
| sample_lead | input | 4 | Per chip: 1 = sample on leading edge, 0 = on trailing edge |
| sclk | output | 1 | Serial bit clock |
| drive_stb | output | 1 | One-cycle drive strobe |
| sample_stb | output | 1 | One-cycle sample strobe |

## Verification
Count the clock edges from the first edge of a frame, starting at 0. The line changes and the strobes are high together, right after edge H*k−1, where H is half the product of the two ratios. After a stop, both return to idle right after the next edge. The bench sweeps every ratio pair, both idle levels and several edge choices. In each frame it samples on the falling clock edge following edge i. It compares the outputs there with values derived from (i+1)/H and (i+1) mod H. The only exception is the one quiet cycle used to load the configuration, which is checked as idle.

// File: rtl/serclk_pkg.sv
`timescale 1ns/1ps
package serclk_pkg;
   localparam int unsigned DIV1_SEL_W = 2;
   localparam int unsigned DIV1_CODES = 1 << DIV1_SEL_W;
   localparam int unsigned DIV2_SEL_W = 2;

   typedef struct packed {
      logic drive_lead;
      logic sample_lead;
   } edge_sel_t;

   // exponent of the second-stage half ratio; codes above the limit saturate
   function automatic int unsigned div2_half_exp(input logic [DIV2_SEL_W-1:0] code,
                                                 input int unsigned max_log);
      if (int'(code) > int'(max_log)) return max_log;
      return int'(code);
   endfunction
endpackage

// File: rtl/serclk_frame_cfg.sv
`timescale 1ns/1ps
module serclk_frame_cfg #(
   parameter int unsigned NUM_CS       = 4,
   parameter int unsigned CS_W         = 2,
   parameter int unsigned C1_W         = 4,
   parameter int unsigned H2_W         = 2,
   parameter int unsigned DIV2_MAX_LOG = 2,
   parameter int unsigned DIV1_RATIO [serclk_pkg::DIV1_CODES] = '{2, 4, 7, 10}
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic                                      run,
   input  logic [CS_W-1:0]                           cs_idx,
   input  logic [serclk_pkg::DIV1_SEL_W-1:0]         div1_sel,
   input  logic [NUM_CS*serclk_pkg::DIV2_SEL_W-1:0]  div2_sel_flat,
   input  logic [NUM_CS-1:0]                         drive_lead,
   input  logic [NUM_CS-1:0]                         sample_lead,
   output logic [C1_W-1:0]                           r1_ratio,
   output logic [H2_W-1:0]                           half_m1,
   output serclk_pkg::edge_sel_t                     edges
);
   import serclk_pkg::*;

   logic [DIV2_SEL_W-1:0] code_a  [NUM_CS];
   edge_sel_t             edge_a  [NUM_CS];

   for (genvar c = 0; c < NUM_CS; c++) begin : g_chip
      assign code_a[c] = div2_sel_flat[c*DIV2_SEL_W +: DIV2_SEL_W];
      assign edge_a[c] = '{drive_lead: drive_lead[c], sample_lead: sample_lead[c]};
   end

   logic [DIV2_SEL_W-1:0] sel_code;
   edge_sel_t             sel_edges;
   logic [C1_W-1:0]       r1_next;
   logic [H2_W-1:0]       half_next;
   int unsigned           hexp;

   always_comb begin
      sel_code  = code_a[0];
      sel_edges = edge_a[0];
      for (int c = 0; c < NUM_CS; c++) begin
         if (int'(cs_idx) == c) begin
            sel_code  = code_a[c];
            sel_edges = edge_a[c];
         end
      end
      r1_next   = C1_W'(DIV1_RATIO[div1_sel]);
      hexp      = div2_half_exp(sel_code, DIV2_MAX_LOG);
      half_next = H2_W'((1 << hexp) - 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r1_ratio <= C1_W'(DIV1_RATIO[0]);
         half_m1  <= '0;
         edges    <= '0;
      end else if (!run) begin
         r1_ratio <= r1_next;
         half_m1  <= half_next;
         edges    <= sel_edges;
      end
   end
endmodule

// File: rtl/serclk_div1_stage.sv
`timescale 1ns/1ps
module serclk_div1_stage #(
   parameter int unsigned C1_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [C1_W-1:0] ratio,
   output logic            tick
);
   logic [C1_W-1:0] cnt_q;
   logic            last;

   assign last = (cnt_q == ratio - C1_W'(1));
   assign tick = run & last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!run || last)  cnt_q <= '0;
      else                    cnt_q <= cnt_q + C1_W'(1);
   end
endmodule

// File: rtl/serclk_div2_stage.sv
`timescale 1ns/1ps
module serclk_div2_stage #(
   parameter int unsigned H2_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            tick,
   input  logic [H2_W-1:0] half_m1,
   output logic            phase,
   output logic            toggle
);
   logic [H2_W-1:0] h_q;

   assign toggle = tick & (h_q == half_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_q   <= '0;
         phase <= 1'b0;
      end else if (!run) begin
         h_q   <= '0;
         phase <= 1'b0;
      end else if (tick) begin
         if (h_q == half_m1) begin
            h_q   <= '0;
            phase <= ~phase;
         end else begin
            h_q   <= h_q + H2_W'(1);
         end
      end
   end
endmodule

// File: rtl/serclk_strobe_gen.sv
`timescale 1ns/1ps
module serclk_strobe_gen (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  toggle,
   input  logic                  phase,
   input  serclk_pkg::edge_sel_t edges,
   output logic                  drive_stb,
   output logic                  sample_stb
);
   logic lead_now;

   // phase low before a toggle means the coming change leaves idle
   assign lead_now = ~phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drive_stb  <= 1'b0;
         sample_stb <= 1'b0;
      end else begin
         drive_stb  <= toggle & (lead_now == edges.drive_lead);
         sample_stb <= toggle & (lead_now == edges.sample_lead);
      end
   end
endmodule

// File: rtl/serclk_prescaler.sv
`timescale 1ns/1ps
module serclk_prescaler #(
   parameter int unsigned NUM_CS       = 4,
   parameter int unsigned DIV1_CNT_W   = 4,
   parameter int unsigned DIV2_MAX_LOG = 2,
   parameter int unsigned DIV1_RATIO [serclk_pkg::DIV1_CODES] = '{2, 4, 7, 10},
   localparam int unsigned CS_W        = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
   localparam int unsigned H2_W        = DIV2_MAX_LOG,
   localparam int unsigned FLAT_W      = NUM_CS * serclk_pkg::DIV2_SEL_W
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              pre_en,
   input  logic                              frame_go,
   input  logic [serclk_pkg::DIV1_SEL_W-1:0] div1_sel,
   input  logic                              idle_inv,
   input  logic [CS_W-1:0]                   cs_idx,
   input  logic [FLAT_W-1:0]                 div2_sel_flat,
   input  logic [NUM_CS-1:0]                 drive_lead,
   input  logic [NUM_CS-1:0]                 sample_lead,
   output logic                              sclk,
   output logic                              drive_stb,
   output logic                              sample_stb
);
   import serclk_pkg::*;

   if (NUM_CS < 1) begin : g_bad_cs
      $error("serclk_prescaler: NUM_CS must be at least 1");
   end
   if (DIV2_MAX_LOG < 1) begin : g_bad_div2
      $error("serclk_prescaler: DIV2_MAX_LOG must be at least 1");
   end
   for (genvar k = 0; k < DIV1_CODES; k++) begin : g_div1_chk
      if (DIV1_RATIO[k] < 2 || DIV1_RATIO[k] >= (1 << DIV1_CNT_W)) begin : g_bad_ratio
         $error("serclk_prescaler: first-stage ratio out of counter range");
      end
   end

   logic                  run;
   logic [DIV1_CNT_W-1:0] r1_ratio;
   logic [H2_W-1:0]       half_m1;
   edge_sel_t             edges;
   logic                  tick;
   logic                  phase;
   logic                  toggle;

   assign run = pre_en & frame_go;

   serclk_frame_cfg #(
      .NUM_CS(NUM_CS), .CS_W(CS_W), .C1_W(DIV1_CNT_W), .H2_W(H2_W),
      .DIV2_MAX_LOG(DIV2_MAX_LOG), .DIV1_RATIO(DIV1_RATIO)
   ) cfg_i (
      .clk(clk), .rst_n(rst_n), .run(run), .cs_idx(cs_idx), .div1_sel(div1_sel),
      .div2_sel_flat(div2_sel_flat), .drive_lead(drive_lead), .sample_lead(sample_lead),
      .r1_ratio(r1_ratio), .half_m1(half_m1), .edges(edges)
   );

   serclk_div1_stage #(.C1_W(DIV1_CNT_W)) st1_i (
      .clk(clk), .rst_n(rst_n), .run(run), .ratio(r1_ratio), .tick(tick)
   );

   serclk_div2_stage #(.H2_W(H2_W)) st2_i (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .half_m1(half_m1),
      .phase(phase), .toggle(toggle)
   );

   serclk_strobe_gen stb_i (
      .clk(clk), .rst_n(rst_n), .toggle(toggle), .phase(phase), .edges(edges),
      .drive_stb(drive_stb), .sample_stb(sample_stb)
   );

   assign sclk = phase ^ idle_inv;
endmodule

// File: rtl/serclk_prescaler_chk.sv
`timescale 1ns/1ps
module serclk_prescaler_chk (
   input logic clk,
   input logic rst_n,
   input logic pre_en,
   input logic frame_go,
   input logic idle_inv,
   input logic sclk,
   input logic drive_stb,
   input logic sample_stb
);
   // R8
   no_strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pre_en && frame_go) |=> (!drive_stb && !sample_stb));

   // R7
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pre_en && frame_go) |=> (sclk == idle_inv));

   // R5
   drive_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_stb && $stable(idle_inv)) |-> (sclk != $past(sclk)));

   // R6
   sample_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_stb && $stable(idle_inv)) |-> (sclk != $past(sclk)));
endmodule

bind serclk_prescaler serclk_prescaler_chk chk_i (
   .clk(clk), .rst_n(rst_n), .pre_en(pre_en), .frame_go(frame_go),
   .idle_inv(idle_inv), .sclk(sclk), .drive_stb(drive_stb), .sample_stb(sample_stb)
);

// File: tb/serclk_prescaler_tb_top.sv
`timescale 1ns/1ps
module serclk_prescaler_tb_top;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       pre_en, frame_go, idle_inv;
   logic [1:0] div1_sel, cs_idx;
   logic [7:0] div2_sel_flat;
   logic [3:0] drive_lead, sample_lead;
   logic       sclk, drive_stb, sample_stb;
   int         tests = 0;
   int         fails = 0;

   always #10 clk = ~clk;

   serclk_prescaler dut_i (
      .clk(clk), .rst_n(rst_n), .pre_en(pre_en), .frame_go(frame_go),
      .div1_sel(div1_sel), .idle_inv(idle_inv), .cs_idx(cs_idx),
      .div2_sel_flat(div2_sel_flat), .drive_lead(drive_lead), .sample_lead(sample_lead),
      .sclk(sclk), .drive_stb(drive_stb), .sample_stb(sample_stb)
   );

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic report();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   function automatic int r1_of(input int code);
      case (code)
         0: return 2;
         1: return 4;
         2: return 7;
         default: return 10;
      endcase
   endfunction

   function automatic int r2_of(input int code);
      if (code == 0) return 2;
      if (code == 1) return 4;
      return 8;
   endfunction

   task automatic check_idle(input string tag);
      chk(sclk == idle_inv, {tag, " sclk idle"}, int'(sclk), int'(idle_inv));
      chk(!drive_stb && !sample_stb, {tag, " strobes quiet"},
          int'({drive_stb, sample_stb}), 0);
   endtask

   // one frame: configure, one quiet cycle to load, run ncyc cycles, stop
   task automatic frame(input int d1, input int d2, input int cs, input int inv,
                        input bit drv, input bit smp, input int ncyc,
                        input bit perturb, input bit stop_en);
      int h;
      h = r1_of(d1) * r2_of(d2) / 2;
      div1_sel = 2'(d1);
      cs_idx   = 2'(cs);
      idle_inv = inv[0];
      for (int c = 0; c < 4; c++) begin
         div2_sel_flat[2*c +: 2] = (c == cs) ? 2'(d2) : 2'((d2 + 1 + c) % 4);
         drive_lead[c]  = (c == cs) ? drv : ~drv;
         sample_lead[c] = (c == cs) ? smp : ~smp;
      end
      @(posedge clk); @(negedge clk);
      check_idle("R8 pre-frame");
      pre_en   = 1'b1;
      frame_go = 1'b1;
      for (int i = 0; i < ncyc; i++) begin
         int k, n;
         bit tog, lead, ph;
         @(posedge clk); @(negedge clk);
         k    = i + 1;
         n    = k / h;
         tog  = (k % h) == 0;
         ph   = n[0];
         lead = tog && n[0];
         chk(sclk == (ph ^ inv[0]), "R1 R2 R3 R4 R7 sclk", int'(sclk), int'(ph ^ inv[0]));
         chk(drive_stb == (tog && (lead == drv)), "R5 drive_stb",
             int'(drive_stb), int'(tog && (lead == drv)));
         chk(sample_stb == (tog && (lead == smp)), "R6 sample_stb",
             int'(sample_stb), int'(tog && (lead == smp)));
         if (perturb && i == 3) begin
            // R9: mid-frame changes must not alter this frame
            cs_idx        = 2'(cs + 1);
            div1_sel      = 2'(d1 + 1);
            div2_sel_flat = ~div2_sel_flat;
            drive_lead    = ~drive_lead;
            sample_lead   = ~sample_lead;
         end
      end
      if (stop_en) pre_en = 1'b0;
      else         frame_go = 1'b0;
      for (int j = 0; j < 3; j++) begin
         @(posedge clk); @(negedge clk);
         check_idle("R8 stopped");
      end
      frame_go = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      report();
      $finish;
   end

   initial begin
      rst_n = 1'b0; pre_en = 1'b0; frame_go = 1'b0; idle_inv = 1'b1;
      div1_sel = '0; cs_idx = '0; div2_sel_flat = '0;
      drive_lead = '0; sample_lead = '0;
      repeat (3) @(negedge clk);
      check_idle("R10 reset inv");
      idle_inv = 1'b0;
      @(negedge clk);
      check_idle("R10 reset");
      rst_n = 1'b1;
      // R8: enable low with frame request high stays idle
      frame_go = 1'b1;
      for (int j = 0; j < 4; j++) begin
         @(posedge clk); @(negedge clk);
         check_idle("R8 disabled");
      end
      frame_go = 1'b0;
      for (int d1 = 0; d1 < 4; d1++)
         for (int d2 = 0; d2 < 4; d2++)
            for (int inv = 0; inv < 2; inv++)
               for (int e = 0; e < 4; e++) begin
                  int h;
                  h = r1_of(d1) * r2_of(d2) / 2;
                  frame((d1 + e) % 4 == 0 ? d1 : d1, d2, (d1 + d2 + e) % 4, inv,
                        1'((d1 + e) & 1), 1'((d2 + inv + (e >> 1)) & 1),
                        4 * h + 3, e == 1, e == 2);
               end
      // R4: stop partway through a bit, restart while frame_go held, first bit full
      frame(2, 0, 1, 0, 1'b1, 1'b0, 10, 1'b0, 1'b1);
      frame(2, 0, 1, 0, 1'b1, 1'b0, 30, 1'b0, 1'b0);
      // R3 slowest: 10 * 8 = 80-cycle period
      frame(3, 3, 2, 1, 1'b0, 1'b1, 170, 1'b0, 1'b0);
      report();
      $finish;
   end
endmodule